// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier

This block multiplies two W-bit operands over W clock cycles using one adder. A start pulse takes in the multiplicand, the multiplier and a mode bit. The block then runs one add-or-skip decision and one right shift per cycle on a combined accumulator and multiplier register. When it finishes, the 2W-bit product sits on `product_o`. During the run, the same port shows the partial product as it builds up.

In unsigned mode both operands are plain binary values. In signed mode both are two's complement. If the multiplier is negative, the block negates both operands before the run, so the multiplier it works with is never negative. The partial product is then kept sign-extended in a register one bit wider than the operands. This extra bit also covers the most negative operand value.

A caller pulses `start_i` while `busy_o` is low. It then waits for the one-cycle `done_o` pulse and reads `product_o`, which holds its value until the next accepted start.

Top module: `shiftmul_core`

## Requirements
- R1: While `rst_ni` is low, `busy_o` and `done_o` are low and `product_o` is zero.
- R2: A `start_i` pulse seen while `busy_o` is low loads the operands and the mode. `busy_o` is high from the next cycle on.
- R3: `busy_o` stays high for exactly W cycles. `done_o` is high for one cycle, the first cycle with `busy_o` low again, and is never high together with `busy_o`.
- R4: With `signed_i`=0, the final `product_o` equals the unsigned product of the two operands, for example 13 × 11 = 143 (16'h008F at W=8).
- R5: With `signed_i`=1, a negative multiplicand and a non-negative multiplier give the two's complement product, for example −13 × 11 = 16'hFF71.
- R6: With `signed_i`=1 and a negative multiplier, the product is correct for either sign of multiplicand: 13 × −11 = 16'hFF71 and −13 × −11 = 16'h008F.
- R7: In signed mode, the value −2^(W−1) works in either operand or in both: −128 × −128 = 16'h4000 and −128 × 127 = 16'hC080.
- R8: A `start_i` seen while `busy_o` is high is ignored. The run in progress keeps its operands, its length and its result.
- R9: After `done_o`, `product_o` keeps its value until the next accepted start, whatever the other inputs do.
- R10: In unsigned mode, an operand whose top bit is set is a large positive value: 255 × 255 = 16'hFE01.
- R11: Let the prepared operands be the inputs, with both negated when the mode is signed and the multiplier is negative. After k steps (k = 0 in the cycle after the start), the low W−k bits of `product_o` equal the prepared multiplier shifted right by k. The upper bits equal the prepared multiplicand times the low k bits of the prepared multiplier. The result is taken modulo 2^(2W).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Single-cycle request to begin a multiply |
| signed_i | input | 1 | 1 = two's complement operands, 0 = unsigned |
| mcand_i | input | W | Multiplicand |
| mplier_i | input | W | Multiplier |
| busy_o | output | 1 | Multiply in progress |
| done_o | output | 1 | One-cycle pulse when the product is final |
| product_o | output | 2W | Accumulator and multiplier register; the product once done |

## Verification
The assertions check the handshake on every cycle: a start accepted while idle raises busy, runs last exactly W cycles, done is a single-cycle pulse outside busy, and the product holds while idle. They also compare every final product with a product computed from the operands captured at the accepted start. Whether that comparison happens in signed or unsigned form, with negative or most-negative operands, depends on the operands each scenario supplies. Only the bench's cycle-by-cycle model shows the shape of the partial product between steps and the effect of a start issued mid-run.

// File: rtl/shiftmul_pkg.sv
package shiftmul_pkg;
  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_RUN  = 1'b1
  } phase_e;

  function automatic int unsigned cnt_bits(int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/shiftmul_operand_prep.sv
// Extends operands to W+1 bits; negates both when signed and multiplier < 0.
module shiftmul_operand_prep #(
  parameter int unsigned W = 8
) (
  input  logic         signed_i,
  input  logic [W-1:0] mcand_i,
  input  logic [W-1:0] mplier_i,
  output logic [W:0]   m_o,
  output logic [W-1:0] q_o
);
  logic [W:0] mc_ext;
  logic       flip;

  always_comb begin
    mc_ext = signed_i ? {mcand_i[W-1], mcand_i} : {1'b0, mcand_i};
    flip   = signed_i & mplier_i[W-1];
    m_o    = flip ? (~mc_ext + 1'b1) : mc_ext;
    // -2^(W-1) negates to the same bit pattern, read as unsigned 2^(W-1)
    q_o    = flip ? (~mplier_i + 1'b1) : mplier_i;
  end
endmodule

// File: rtl/shiftmul_step_unit.sv
// One add-or-skip decision followed by a right shift of {A,Q}.
module shiftmul_step_unit #(
  parameter int unsigned W = 8
) (
  input  logic         sgn_i,
  input  logic [W:0]   a_i,
  input  logic [W-1:0] q_i,
  input  logic [W:0]   m_i,
  output logic [W:0]   a_o,
  output logic [W-1:0] q_o
);
  localparam int unsigned SW = W + 2;

  logic [SW-1:0] a_x, m_x, sum;

  always_comb begin
    a_x = {(sgn_i & a_i[W]), a_i};
    m_x = {(sgn_i & m_i[W]), m_i};
    sum = q_i[0] ? (a_x + m_x) : a_x;
    a_o = sum[SW-1:1];
    q_o = {sum[0], q_i[W-1:1]};
  end
endmodule

// File: rtl/shiftmul_seq_ctrl.sv
module shiftmul_seq_ctrl
  import shiftmul_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic load_o,
  output logic step_o,
  output logic busy_o,
  output logic done_o
);
  localparam int unsigned CW = cnt_bits(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  phase_e        phase_q;
  logic [CW-1:0] cnt_q;
  logic          done_q;

  assign busy_o = (phase_q == PH_RUN);
  assign load_o = start_i & ~busy_o;
  assign step_o = busy_o;
  assign done_o = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (load_o) begin
        phase_q <= PH_RUN;
        cnt_q   <= '0;
      end else if (busy_o) begin
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == LAST) begin
          phase_q <= PH_IDLE;
          done_q  <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/shiftmul_core.sv
module shiftmul_core
  import shiftmul_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic           signed_i,
  input  logic [W-1:0]   mcand_i,
  input  logic [W-1:0]   mplier_i,
  output logic           busy_o,
  output logic           done_o,
  output logic [2*W-1:0] product_o
);
  localparam int unsigned AW = W + 1;

  logic          load, step;
  logic [AW-1:0] m_prep, m_q, a_q, a_nxt;
  logic [W-1:0]  q_prep, q_q, q_nxt;
  logic          sgn_q;

  shiftmul_operand_prep #(.W(W)) u_prep (
    .signed_i (signed_i),
    .mcand_i  (mcand_i),
    .mplier_i (mplier_i),
    .m_o      (m_prep),
    .q_o      (q_prep)
  );

  shiftmul_step_unit #(.W(W)) u_step (
    .sgn_i (sgn_q),
    .a_i   (a_q),
    .q_i   (q_q),
    .m_i   (m_q),
    .a_o   (a_nxt),
    .q_o   (q_nxt)
  );

  shiftmul_seq_ctrl #(.W(W)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .load_o  (load),
    .step_o  (step),
    .busy_o  (busy_o),
    .done_o  (done_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q   <= '0;
      q_q   <= '0;
      m_q   <= '0;
      sgn_q <= 1'b0;
    end else if (load) begin
      a_q   <= '0;
      q_q   <= q_prep;
      m_q   <= m_prep;
      sgn_q <= signed_i;
    end else if (step) begin
      a_q <= a_nxt;
      q_q <= q_nxt;
    end
  end

  // extension bit a_q[W] stays internal; the 2W-bit result fits below it
  assign product_o = {a_q[W-1:0], q_q};
endmodule

// File: rtl/shiftmul_core_chk.sv
module shiftmul_core_chk #(
  parameter int unsigned W = 8
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           start_i,
  input logic           signed_i,
  input logic [W-1:0]   mcand_i,
  input logic [W-1:0]   mplier_i,
  input logic           busy_o,
  input logic           done_o,
  input logic [2*W-1:0] product_o
);
  localparam int unsigned CW = $clog2(W + 1) + 1;
  localparam logic [CW-1:0] FULL = CW'(W);
  localparam logic [CW-1:0] PENULT = CW'(W - 1);

  logic           accept;
  logic [CW-1:0]  run_len;
  logic [2*W-1:0] exp_q;

  assign accept = start_i & ~busy_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_len <= '0;
      exp_q   <= '0;
    end else begin
      if (accept) begin
        run_len <= '0;
        if (signed_i)
          exp_q <= {{W{mcand_i[W-1]}}, mcand_i} * {{W{mplier_i[W-1]}}, mplier_i};
        else
          exp_q <= {{W{1'b0}}, mcand_i} * {{W{1'b0}}, mplier_i};
      end else if (busy_o) begin
        run_len <= run_len + 1'b1;
      end
    end
  end

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      a_reset_r1: assert (!busy_o && !done_o && product_o == '0)
        else $error("R1 outputs not cleared in reset");
    end
  end

  p_start_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o |=> busy_o);

  p_done_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  p_run_len_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> run_len == FULL);

  p_busy_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && run_len < PENULT |=> busy_o);

  // final value vs operands captured at accept; covers R5 R6 R7 R8 R10 too
  p_product_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> product_o == exp_q);

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && !start_i |=> $stable(product_o));
endmodule

bind shiftmul_core shiftmul_core_chk #(.W(W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .signed_i  (signed_i),
  .mcand_i   (mcand_i),
  .mplier_i  (mplier_i),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .product_o (product_o)
);

// File: tb/shiftmul_core_tb_top.sv
`timescale 1ns/1ps
module shiftmul_core_tb_top;
  localparam int W = 8;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           start = 1'b0;
  logic           sgn = 1'b0;
  logic [W-1:0]   mc = '0;
  logic [W-1:0]   mq = '0;
  logic           busy, done;
  logic [2*W-1:0] prod;

  int    checks = 0;
  int    fails = 0;
  bit    chk_en = 1'b0;
  bit    ended = 1'b0;
  string cur_req = "R4";

  always #10 clk = ~clk;

  shiftmul_core #(.W(W)) dut_i (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .start_i   (start),
    .signed_i  (sgn),
    .mcand_i   (mc),
    .mplier_i  (mq),
    .busy_o    (busy),
    .done_o    (done),
    .product_o (prod)
  );

  // ---------------- behavioural reference ----------------
  bit             m_busy, m_done;
  int             m_k;
  longint         m_a, m_b;
  logic [2*W-1:0] m_prod;

  function automatic logic [2*W-1:0] partial(longint a, longint b, int k);
    longint p;
    longint mask;
    mask = (longint'(1) <<< k) - 1;
    p = a * (b & mask);
    p = p <<< (W - k);
    p = p + (b >>> k);
    return p[2*W-1:0];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy <= 1'b0; m_done <= 1'b0; m_k <= 0;
      m_a <= 0; m_b <= 0; m_prod <= '0;
    end else begin
      m_done <= 1'b0;
      if (!m_busy && start) begin
        longint a, b;
        if (sgn) begin
          a = longint'($signed(mc));
          b = longint'($signed(mq));
          if (b < 0) begin a = -a; b = -b; end
        end else begin
          a = longint'(mc);
          b = longint'(mq);
        end
        m_a <= a; m_b <= b; m_k <= 0; m_busy <= 1'b1;
        m_prod <= partial(a, b, 0);
      end else if (m_busy) begin
        m_k <= m_k + 1;
        m_prod <= partial(m_a, m_b, m_k + 1);
        if (m_k + 1 == W) begin
          m_busy <= 1'b0;
          m_done <= 1'b1;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (chk_en && !ended) begin
      checks += 3;
      if (busy !== m_busy) begin
        fails++;
        $display("FAIL R2 R3 busy_o actual=%0b expected=%0b at %0t", busy, m_busy, $time);
      end
      if (done !== m_done) begin
        fails++;
        $display("FAIL R3 done_o actual=%0b expected=%0b at %0t", done, m_done, $time);
      end
      if (prod !== m_prod) begin
        fails++;
        $display("FAIL %s product_o actual=%h expected=%h at %0t",
                 m_busy ? "R11" : (m_done ? cur_req : "R9"), prod, m_prod, $time);
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic check_eq(string req, logic [2*W-1:0] act, logic [2*W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [2*W-1:0] ref_mul(logic [W-1:0] a, logic [W-1:0] b, bit s);
    longint r;
    if (s) r = longint'($signed(a)) * longint'($signed(b));
    else   r = longint'(a) * longint'(b);
    return r[2*W-1:0];
  endfunction

  task automatic run_op(logic [W-1:0] a, logic [W-1:0] b, bit s, string req,
                        int mid_start = -1);
    bit seen;
    seen = 1'b0;
    @(negedge clk);
    cur_req = req;
    mc = a; mq = b; sgn = s; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < W + 4 && !seen; i++) begin
      if (i == mid_start) begin
        mc = ~a; mq = ~b; sgn = ~s; start = 1'b1;   // R8: must be ignored
      end else begin
        start = 1'b0;
      end
      if (done) seen = 1'b1;
      else @(negedge clk);
    end
    start = 1'b0;
    checks++;
    if (!seen) begin
      fails++;
      $display("FAIL R3 done_o actual=0 expected=1 within %0d cycles", W + 4);
    end else begin
      check_eq(req, prod, ref_mul(a, b, s));
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!ended) begin
      ended = 1'b1;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R1: reset state
    check_eq("R1", {busy, done, prod}, '0);
    rst_n = 1'b1;
    chk_en = 1'b1;

    run_op(8'd13, 8'd11, 1'b0, "R4");
    run_op(8'd0, 8'd200, 1'b0, "R4");
    run_op(8'd255, 8'd255, 1'b0, "R10");
    run_op(8'd200, 8'd3, 1'b0, "R10");
    run_op(8'hF3, 8'd11, 1'b1, "R5");       // -13 * 11
    run_op(8'd13, 8'hF5, 1'b1, "R6");       // 13 * -11
    run_op(8'hF3, 8'hF5, 1'b1, "R6");       // -13 * -11
    run_op(8'h80, 8'h80, 1'b1, "R7");
    run_op(8'h80, 8'h7F, 1'b1, "R7");
    run_op(8'h7F, 8'h80, 1'b1, "R7");
    run_op(8'd5, 8'd6, 1'b0, "R8", 3);
    run_op(8'hF0, 8'h0F, 1'b1, "R8", 0);

    // R9: idle with changing inputs, product must hold
    begin
      logic [2*W-1:0] held;
      held = prod;
      for (int i = 0; i < 6; i++) begin
        @(negedge clk);
        mc = 8'(i * 37); mq = 8'(i * 91); sgn = i[0];
      end
      check_eq("R9", prod, held);
    end

    for (int n = 0; n < 40; n++) begin
      logic [W-1:0] a, b;
      bit s;
      a = 8'($urandom);
      b = 8'($urandom);
      s = n[0];
      run_op(a, b, s, s ? "R6" : "R4");
    end

    repeat (4) @(negedge clk);
    if (!ended) begin
      ended = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule